// File: doc/BRIEF.md
# Serial Programmer Command Interpreter

This block sits between a byte-oriented host link and a target-programming frame engine. The host sends a command letter, optionally followed by argument bytes, through a byte valid/ready receive port. The interpreter keeps the selected device code and a 16-bit target address. It translates each command into one or more 4-byte target frames, which it hands to a separate frame engine through a request/done handshake. It then returns the answer through a byte valid/ready transmit port. The answer is read-back data, a fixed identifier, version digits, a device list, a carriage return (0x0D) meaning success, or '?' (0x3F) meaning the command was refused.

Identification commands work in any state. Commands that touch the target are refused unless the stored device code belongs to the supported set. Address-driven reads and writes form their frames from the stored address. The address steps forward by one after a word read and after a high-byte write.

A byte-wide device (code 0x86) has a different frame layout. On such a device, a read returns one byte and leaves the address unchanged.

Top module: `prog_cmd_interp`

## Requirements
- R1: After reset the block accepts a command byte (rx_ready=1), with tx_valid=0 and eng_req=0. A command that succeeds without returning data replies with the single byte 0x0D.
- R2: A 0x1B byte received in the command position is dropped without any reply or frame, and the next byte is decoded as a command.
- R3: 'A' (0x41) takes two bytes, high then low, loads the 16-bit address, and replies 0x0D.
- R4: These commands are accepted with any device code:
  - 'T' (0x54) takes one byte, stores it as the device code, and replies 0x0D.
  - 'S' (0x53) replies with the 7 ASCII characters "HOSTPRG".
  - 'V' (0x56) replies "20" and 'v' (0x76) replies "10", each digit being 0x30 plus the number.
  - 'p' (0x70) replies 'S'.
  - 'x' (0x78) and 'y' (0x79) each consume one byte and reply 0x0D.
- R5: 't' (0x74) replies 0x12, 0x13, 0x20, 0x28, 0x38, 0x48, 0x86 and then 0x00.
- R6: If the device code is outside {0x12, 0x13, 0x20, 0x28, 0x38, 0x48, 0x86, 0x40, 0x41}, any other command replies 0x3F. No frame is issued and no argument bytes are consumed.
- R7: An unrecognised command letter replies 0x3F with no frame.
- R8: 'R' (0x52) on a word device issues frame {0x28,ah,al,0x00}, then frame {0x20,ah,al,0x00}. It returns the two read-back bytes in that order and then adds 1 to the address, wrapping 0xFFFF to 0x0000. On device 0x86 it issues the single frame {ah<<3|0x01,al,0x00,0x00}, returns one byte, and leaves the address unchanged.
- R9: 'C' (0x43) with data dd issues {0x48,ah,al,dd}, replies 0x0D and then adds 1 to the address. 'c' (0x63) issues {0x40,ah,al,dd}, replies 0x0D and does not change the address. 'C' on device 0x86 consumes its byte and replies 0x3F with no frame.
- R10: ':' (0x3A) takes three bytes b0 b1 b2, issues {b0,b1,b2,0x00}, returns the read-back byte, and then sends 0x0D.
- R11: Only one command is handled at a time:
  - rx_ready stays low from the last byte of a command until its final response byte is accepted.
  - tx_data is held while tx_valid waits for tx_ready.
  - eng_req with a stable eng_frame is held until eng_done.
- R12: On word devices:
  - 'P' (0x50) issues {0xAC,0x53,0x00,0x00} and replies 0x0D.
  - 'd' (0x64) issues {0xA0,ah,al,0x00} and returns the read-back byte.
  - 'e' (0x65) issues {0xAC,0x80,0x04,0x00} and replies 0x0D.
- R13: 's' (0x73) issues three frames {0x30,0x00,sel,0x00} with sel = 0x02, 0x01, 0x00 and returns the three read-back bytes in that order. On device 0x86 it replies 0x3F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Interpreter takes the received byte |
| tx_valid | output | 1 | Response byte available |
| tx_data | output | 8 | Response byte |
| tx_ready | input | 1 | Transmitter takes the response byte |
| eng_req | output | 1 | Frame request to the frame engine |
| eng_frame | output | 32 | Frame, first byte in bits 31:24 |
| eng_done | input | 1 | One-cycle completion of the requested frame |
| eng_rdata | input | 8 | Byte read back in the frame's last position, valid with eng_done |

## Verification
The decoder is driven with:
- identification commands under an unsupported device code;
- target commands under unsupported, word-organised and byte-wide codes;
- ESC bytes in the command position;
- an unknown letter.

These patterns separate the device gate from the decoding itself. A gated command followed by an ordinary command shows that its argument bytes were not consumed.

Reads follow an address load, a low-byte write, a high-byte write, and a load of 0xFFFF. Their frames expose exactly when the address steps and when it wraps.

The frame-engine model answers with a byte computed from the frame, so a swapped or missing frame shows up in the returned data. Holding tx_ready low during a read shows whether new bytes are refused while a response is pending.

// File: rtl/prog_pkg.sv
package prog_pkg;

    localparam logic [7:0] CH_CR  = 8'h0D;
    localparam logic [7:0] CH_ERR = 8'h3F;
    localparam logic [7:0] CH_ESC = 8'h1B;

    localparam logic [7:0] OP_TYPE  = 8'h54;
    localparam logic [7:0] OP_IDENT = 8'h53;
    localparam logic [7:0] OP_SWV   = 8'h56;
    localparam logic [7:0] OP_HWV   = 8'h76;
    localparam logic [7:0] OP_LIST  = 8'h74;
    localparam logic [7:0] OP_PTYP  = 8'h70;
    localparam logic [7:0] OP_LEDON = 8'h78;
    localparam logic [7:0] OP_LEDOF = 8'h79;
    localparam logic [7:0] OP_ENTER = 8'h50;
    localparam logic [7:0] OP_ADDR  = 8'h41;
    localparam logic [7:0] OP_WRLO  = 8'h63;
    localparam logic [7:0] OP_WRHI  = 8'h43;
    localparam logic [7:0] OP_RDPM  = 8'h52;
    localparam logic [7:0] OP_WRDM  = 8'h44;
    localparam logic [7:0] OP_RDDM  = 8'h64;
    localparam logic [7:0] OP_LEAVE = 8'h4C;
    localparam logic [7:0] OP_ERASE = 8'h65;
    localparam logic [7:0] OP_LOCK  = 8'h6C;
    localparam logic [7:0] OP_SIG   = 8'h73;
    localparam logic [7:0] OP_PAGE  = 8'h6D;
    localparam logic [7:0] OP_RAW   = 8'h3A;

    localparam int LIST_LEN  = 7;
    localparam int EXTRA_LEN = 2;
    localparam logic [7:0] DEV_LISTED [LIST_LEN] =
        '{8'h12, 8'h13, 8'h20, 8'h28, 8'h38, 8'h48, 8'h86};
    localparam logic [7:0] DEV_EXTRA [EXTRA_LEN] = '{8'h40, 8'h41};
    localparam logic [7:0] DEV_BYTEWIDE = 8'h86;

    localparam int ID_LEN  = 7;
    localparam int SEQ_MAX = (ID_LEN > LIST_LEN + 1) ? ID_LEN : LIST_LEN + 1;
    localparam int IDX_W   = $clog2(SEQ_MAX);
    localparam int ADDR_W  = 16;
    localparam int FRAME_W = 32;

    typedef enum logic [2:0] {
        ST_CMD, ST_ARG, ST_EXEC, ST_ENG, ST_TXD, ST_TXONE, ST_TXSEQ
    } st_e;

    typedef enum logic [2:0] {
        RS_ID, RS_SWV, RS_HWV, RS_LIST, RS_TYPE
    } rsrc_e;

    typedef struct packed {
        st_e                st;
        logic [7:0]         cmd;
        logic [2:0][7:0]    args;
        logic [1:0]         argn;
        logic [1:0]         argi;
        logic [7:0]         dev;
        logic [ADDR_W-1:0]  addr;
        logic [1:0]         step;
        logic [7:0]         rdata;
        logic [7:0]         txb;
        rsrc_e              rsrc;
        logic [IDX_W-1:0]   idx;
    } ctl_t;

endpackage

// File: rtl/prog_dev_check.sv
module prog_dev_check
    import prog_pkg::*;
(
    input  logic [7:0] dev,
    output logic       dev_ok,
    output logic       byte_wide
);
    logic [LIST_LEN-1:0]  hit_list;
    logic [EXTRA_LEN-1:0] hit_extra;

    for (genvar g = 0; g < LIST_LEN; g++) begin : g_list
        assign hit_list[g] = (dev == DEV_LISTED[g]);
    end

    for (genvar g = 0; g < EXTRA_LEN; g++) begin : g_extra
        assign hit_extra[g] = (dev == DEV_EXTRA[g]);
    end

    assign dev_ok    = (|hit_list) | (|hit_extra);
    assign byte_wide = (dev == DEV_BYTEWIDE);
endmodule

// File: rtl/prog_reply_src.sv
module prog_reply_src
    import prog_pkg::*;
#(
    parameter int                  SW_MAJOR = 2,
    parameter int                  SW_MINOR = 0,
    parameter int                  HW_MAJOR = 1,
    parameter int                  HW_MINOR = 0,
    parameter logic [8*ID_LEN-1:0] ID_STR   = "HOSTPRG"
) (
    input  rsrc_e            kind,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       rbyte,
    output logic             rlast
);
    localparam logic [7:0] ASCII_ZERO = 8'h30;
    localparam logic [7:0] TYPE_CHAR  = 8'h53;

    always_comb begin
        rbyte = 8'h00;
        rlast = 1'b1;
        case (kind)
            RS_ID: begin
                for (int k = 0; k < ID_LEN; k++) begin
                    if (int'(idx) == k) rbyte = ID_STR[8*(ID_LEN-1-k) +: 8];
                end
                rlast = (int'(idx) == ID_LEN - 1);
            end
            RS_SWV: begin
                rbyte = (idx == '0) ? 8'(ASCII_ZERO + 8'(SW_MAJOR))
                                    : 8'(ASCII_ZERO + 8'(SW_MINOR));
                rlast = (int'(idx) == 1);
            end
            RS_HWV: begin
                rbyte = (idx == '0) ? 8'(ASCII_ZERO + 8'(HW_MAJOR))
                                    : 8'(ASCII_ZERO + 8'(HW_MINOR));
                rlast = (int'(idx) == 1);
            end
            RS_LIST: begin
                for (int k = 0; k < LIST_LEN; k++) begin
                    if (int'(idx) == k) rbyte = DEV_LISTED[k];
                end
                rlast = (int'(idx) == LIST_LEN);
            end
            default: begin
                rbyte = TYPE_CHAR;
                rlast = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/prog_cmd_interp.sv
module prog_cmd_interp
    import prog_pkg::*;
#(
    parameter int                  SW_MAJOR = 2,
    parameter int                  SW_MINOR = 0,
    parameter int                  HW_MAJOR = 1,
    parameter int                  HW_MINOR = 0,
    parameter logic [8*ID_LEN-1:0] ID_STR   = "HOSTPRG"
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_valid,
    input  logic [7:0]         rx_data,
    output logic               rx_ready,
    output logic               tx_valid,
    output logic [7:0]         tx_data,
    input  logic               tx_ready,
    output logic               eng_req,
    output logic [FRAME_W-1:0] eng_frame,
    input  logic               eng_done,
    input  logic [7:0]         eng_rdata
);
    localparam logic [IDX_W-1:0]  IDX_ONE  = 1;
    localparam logic [ADDR_W-1:0] ADDR_ONE = 1;

    ctl_t       ctl_d, ctl_q;
    logic       dev_ok, byte_wide;
    logic [7:0] seq_byte;
    logic       seq_last;

    prog_dev_check u_devchk (
        .dev       (ctl_q.dev),
        .dev_ok    (dev_ok),
        .byte_wide (byte_wide)
    );

    prog_reply_src #(
        .SW_MAJOR (SW_MAJOR),
        .SW_MINOR (SW_MINOR),
        .HW_MAJOR (HW_MAJOR),
        .HW_MINOR (HW_MINOR),
        .ID_STR   (ID_STR)
    ) u_reply (
        .kind  (ctl_q.rsrc),
        .idx   (ctl_q.idx),
        .rbyte (seq_byte),
        .rlast (seq_last)
    );

    // Frame contents follow registered state only, so they stay put while
    // the request is outstanding.
    logic [7:0] ah, al, ahs, d0;
    logic [7:0] sig_sel;
    assign ah  = ctl_q.addr[15:8];
    assign al  = ctl_q.addr[7:0];
    assign ahs = {ctl_q.addr[12:8], 3'b000};
    assign d0  = ctl_q.args[0];

    always_comb begin
        case (ctl_q.step)
            2'd0:    sig_sel = 8'h02;
            2'd1:    sig_sel = 8'h01;
            default: sig_sel = 8'h00;
        endcase
    end

    always_comb begin
        case (ctl_q.cmd)
            OP_ENTER: eng_frame = {8'hAC, 8'h53, 8'h00, 8'h00};
            OP_RDPM: begin
                if (byte_wide)             eng_frame = {ahs | 8'h01, al, 8'h00, 8'h00};
                else if (ctl_q.step == '0) eng_frame = {8'h28, ah, al, 8'h00};
                else                       eng_frame = {8'h20, ah, al, 8'h00};
            end
            OP_WRLO:  eng_frame = byte_wide ? {ahs | 8'h02, al, d0, 8'h00}
                                            : {8'h40, ah, al, d0};
            OP_WRHI:  eng_frame = {8'h48, ah, al, d0};
            OP_WRDM:  eng_frame = byte_wide ? {ahs | 8'h06, al, d0, 8'h00}
                                            : {8'hC0, ah, al, d0};
            OP_RDDM:  eng_frame = byte_wide ? {ahs | 8'h05, al, 8'h00, 8'h00}
                                            : {8'hA0, ah, al, 8'h00};
            OP_ERASE: eng_frame = {8'hAC, 8'h80, 8'h04, 8'h00};
            OP_LOCK:  eng_frame = {8'hAC, 8'hE0 | (d0 & 8'h06), 8'h00, 8'h00};
            OP_PAGE:  eng_frame = {8'h4C, ah, al, 8'h00};
            OP_SIG:   eng_frame = {8'h30, 8'h00, sig_sel, 8'h00};
            OP_RAW:   eng_frame = {ctl_q.args[0], ctl_q.args[1], ctl_q.args[2], 8'h00};
            default:  eng_frame = '0;
        endcase
    end

    logic returns_data;
    logic more_steps;
    assign returns_data = (ctl_q.cmd == OP_RDPM) || (ctl_q.cmd == OP_RDDM) ||
                          (ctl_q.cmd == OP_SIG)  || (ctl_q.cmd == OP_RAW);
    assign more_steps   = ((ctl_q.cmd == OP_RDPM) && !byte_wide && (ctl_q.step == 2'd0)) ||
                          ((ctl_q.cmd == OP_SIG)  && (ctl_q.step != 2'd2));

    always_comb begin
        ctl_d    = ctl_q;
        rx_ready = 1'b0;
        tx_valid = 1'b0;
        tx_data  = 8'h00;
        eng_req  = 1'b0;

        case (ctl_q.st)
            ST_CMD: begin
                rx_ready = 1'b1;
                if (rx_valid) begin
                    ctl_d.cmd  = rx_data;
                    ctl_d.argi = '0;
                    ctl_d.step = '0;
                    ctl_d.idx  = '0;
                    case (rx_data)
                        CH_ESC: ctl_d.st = ST_CMD;
                        OP_TYPE, OP_LEDON, OP_LEDOF: begin
                            ctl_d.argn = 2'd0;
                            ctl_d.st   = ST_ARG;
                        end
                        OP_IDENT: begin ctl_d.rsrc = RS_ID;   ctl_d.st = ST_TXSEQ; end
                        OP_SWV:   begin ctl_d.rsrc = RS_SWV;  ctl_d.st = ST_TXSEQ; end
                        OP_HWV:   begin ctl_d.rsrc = RS_HWV;  ctl_d.st = ST_TXSEQ; end
                        OP_LIST:  begin ctl_d.rsrc = RS_LIST; ctl_d.st = ST_TXSEQ; end
                        OP_PTYP:  begin ctl_d.rsrc = RS_TYPE; ctl_d.st = ST_TXSEQ; end
                        default: begin
                            if (!dev_ok) begin
                                ctl_d.txb = CH_ERR;
                                ctl_d.st  = ST_TXONE;
                            end else begin
                                case (rx_data)
                                    OP_ADDR: begin
                                        ctl_d.argn = 2'd1;
                                        ctl_d.st   = ST_ARG;
                                    end
                                    OP_WRLO, OP_WRHI, OP_WRDM, OP_LOCK: begin
                                        ctl_d.argn = 2'd0;
                                        ctl_d.st   = ST_ARG;
                                    end
                                    OP_RAW: begin
                                        ctl_d.argn = 2'd2;
                                        ctl_d.st   = ST_ARG;
                                    end
                                    OP_ENTER, OP_RDPM, OP_RDDM, OP_ERASE,
                                    OP_PAGE, OP_SIG, OP_LEAVE: begin
                                        ctl_d.st = ST_EXEC;
                                    end
                                    default: begin
                                        ctl_d.txb = CH_ERR;
                                        ctl_d.st  = ST_TXONE;
                                    end
                                endcase
                            end
                        end
                    endcase
                end
            end

            ST_ARG: begin
                rx_ready = 1'b1;
                if (rx_valid) begin
                    case (ctl_q.argi)
                        2'd0:    ctl_d.args[0] = rx_data;
                        2'd1:    ctl_d.args[1] = rx_data;
                        default: ctl_d.args[2] = rx_data;
                    endcase
                    if (ctl_q.argi == ctl_q.argn) ctl_d.st = ST_EXEC;
                    else                          ctl_d.argi = ctl_q.argi + 2'd1;
                end
            end

            ST_EXEC: begin
                ctl_d.txb = CH_CR;
                ctl_d.st  = ST_TXONE;
                case (ctl_q.cmd)
                    OP_TYPE:  ctl_d.dev  = ctl_q.args[0];
                    OP_ADDR:  ctl_d.addr = {ctl_q.args[0], ctl_q.args[1]};
                    OP_LEDON, OP_LEDOF, OP_LEAVE: ctl_d.st = ST_TXONE;
                    OP_WRHI, OP_SIG: begin
                        if (byte_wide) ctl_d.txb = CH_ERR;
                        else           ctl_d.st  = ST_ENG;
                    end
                    default:  ctl_d.st = ST_ENG;
                endcase
            end

            ST_ENG: begin
                eng_req = 1'b1;
                if (eng_done) begin
                    if (returns_data) begin
                        ctl_d.rdata = eng_rdata;
                        ctl_d.st    = ST_TXD;
                    end else begin
                        if (ctl_q.cmd == OP_WRHI) ctl_d.addr = ctl_q.addr + ADDR_ONE;
                        ctl_d.txb = CH_CR;
                        ctl_d.st  = ST_TXONE;
                    end
                end
            end

            ST_TXD: begin
                tx_valid = 1'b1;
                tx_data  = ctl_q.rdata;
                if (tx_ready) begin
                    if (more_steps) begin
                        ctl_d.step = ctl_q.step + 2'd1;
                        ctl_d.st   = ST_ENG;
                    end else begin
                        if ((ctl_q.cmd == OP_RDPM) && !byte_wide)
                            ctl_d.addr = ctl_q.addr + ADDR_ONE;
                        if (ctl_q.cmd == OP_RAW) begin
                            ctl_d.txb = CH_CR;
                            ctl_d.st  = ST_TXONE;
                        end else begin
                            ctl_d.st  = ST_CMD;
                        end
                    end
                end
            end

            ST_TXONE: begin
                tx_valid = 1'b1;
                tx_data  = ctl_q.txb;
                if (tx_ready) ctl_d.st = ST_CMD;
            end

            ST_TXSEQ: begin
                tx_valid = 1'b1;
                tx_data  = seq_byte;
                if (tx_ready) begin
                    if (seq_last) ctl_d.st  = ST_CMD;
                    else          ctl_d.idx = ctl_q.idx + IDX_ONE;
                end
            end

            default: ctl_d.st = ST_CMD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= ST_CMD;
            ctl_q.rsrc <= RS_ID;
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/prog_cmd_interp_chk.sv
module prog_cmd_interp_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_ready,
    input logic        tx_valid,
    input logic [7:0]  tx_data,
    input logic        tx_ready,
    input logic        eng_req,
    input logic [31:0] eng_frame,
    input logic        eng_done
);
    // R11
    rx_tx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_ready && tx_valid));

    // R11
    rx_eng_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_ready && eng_req));

    // R11
    tx_eng_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && eng_req));

    // R11
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R11
    eng_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_done) |=> (eng_req && $stable(eng_frame)));

    // R11
    eng_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_done) |=> !eng_req);
endmodule

bind prog_cmd_interp prog_cmd_interp_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_ready  (rx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready),
    .eng_req   (eng_req),
    .eng_frame (eng_frame),
    .eng_done  (eng_done)
);

// File: tb/sim_prog_cmd_interp.sv
module sim_prog_cmd_interp;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        eng_req;
    logic [31:0] eng_frame;
    logic        eng_done = 1'b0;
    logic [7:0]  eng_rdata = 8'h00;

    int ntot = 0;
    int nbad = 0;
    int nfr  = 0;
    int wcnt = 0;
    logic [31:0] flog [0:7];

    always #(CLK_PERIOD/2) clk = ~clk;

    prog_cmd_interp u0 (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .eng_req(eng_req), .eng_frame(eng_frame),
        .eng_done(eng_done), .eng_rdata(eng_rdata)
    );

    function automatic logic [7:0] mdl(input logic [31:0] f);
        return f[31:24] ^ f[15:8] ^ 8'h3C;
    endfunction

    // frame engine model: answers two cycles after a request
    initial begin
        forever begin
            @(negedge clk);
            eng_done = 1'b0;
            if (eng_req) begin
                if (wcnt == 1) begin
                    eng_done  = 1'b1;
                    eng_rdata = mdl(eng_frame);
                    if (nfr < 8) flog[nfr] = eng_frame;
                    nfr  = nfr + 1;
                    wcnt = 0;
                end else begin
                    wcnt = wcnt + 1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        ntot++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b);
        @(negedge clk);
        tx_ready = 1'b1;
        while (!tx_valid) @(negedge clk);
        b = tx_data;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic expect_byte(input string tag, input logic [7:0] exp);
        logic [7:0] b;
        recv_byte(b);
        chk(tag, {24'h0, b}, {24'h0, exp});
    endtask

    task automatic set_dev(input logic [7:0] dv);
        send_byte(8'h54); send_byte(dv);
        expect_byte("R4 T reply", 8'h0D);
    endtask

    task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
        send_byte(8'h41); send_byte(hi); send_byte(lo);
        expect_byte("R3 A reply", 8'h0D);
    endtask

    task automatic t_reset;
        chk("R1 reset rx_ready", {31'h0, rx_ready}, 32'd1);
        chk("R1 reset tx_valid", {31'h0, tx_valid}, 32'd0);
        chk("R1 reset eng_req",  {31'h0, eng_req},  32'd0);
    endtask

    task automatic t_ident;
        string id = "HOSTPRG";
        send_byte(8'h53);
        for (int i = 0; i < 7; i++) expect_byte("R4 identifier", id[i]);
        send_byte(8'h56);
        expect_byte("R4 sw major", 8'h32);
        expect_byte("R4 sw minor", 8'h30);
        send_byte(8'h76);
        expect_byte("R4 hw major", 8'h31);
        expect_byte("R4 hw minor", 8'h30);
        send_byte(8'h70);
        expect_byte("R4 type", 8'h53);
        send_byte(8'h78); send_byte(8'hFF);
        expect_byte("R4 x reply", 8'h0D);
        send_byte(8'h79); send_byte(8'h00);
        expect_byte("R4 y reply", 8'h0D);
    endtask

    task automatic t_list;
        logic [7:0] lst [8] = '{8'h12, 8'h13, 8'h20, 8'h28, 8'h38, 8'h48, 8'h86, 8'h00};
        send_byte(8'h74);
        for (int i = 0; i < 8; i++) expect_byte("R5 device list", lst[i]);
    endtask

    task automatic t_esc;
        send_byte(8'h1B);
        send_byte(8'h1B);
        send_byte(8'h70);
        expect_byte("R2 esc dropped", 8'h53);
    endtask

    task automatic t_gate;
        set_dev(8'h55);
        nfr = 0;
        send_byte(8'h50);
        expect_byte("R6 gated P", 8'h3F);
        chk("R6 gated no frame", nfr, 0);
        send_byte(8'h41);
        expect_byte("R6 gated A", 8'h3F);
        send_byte(8'h70);
        expect_byte("R6 args not consumed", 8'h53);
        set_dev(8'h41);
        nfr = 0;
        send_byte(8'h65);
        expect_byte("R6 extra code accepted", 8'h0D);
        chk("R12 erase frame", flog[0], 32'hAC800400);
    endtask

    task automatic t_unknown;
        set_dev(8'h38);
        nfr = 0;
        send_byte(8'h5A);
        expect_byte("R7 unknown letter", 8'h3F);
        chk("R7 no frame", nfr, 0);
    endtask

    task automatic t_enter;
        nfr = 0;
        send_byte(8'h50);
        expect_byte("R1 P reply CR", 8'h0D);
        chk("R12 enter frame", flog[0], 32'hAC530000);
    endtask

    task automatic t_read;
        set_addr(8'h12, 8'h34);
        nfr = 0;
        send_byte(8'h52);
        expect_byte("R8 read high", mdl(32'h28123400));
        expect_byte("R8 read low",  mdl(32'h20123400));
        chk("R3 frame address", flog[0], 32'h28123400);
        chk("R8 second frame",  flog[1], 32'h20123400);
        nfr = 0;
        send_byte(8'h52);
        expect_byte("R8 next high", mdl(32'h28123500));
        expect_byte("R8 next low",  mdl(32'h20123500));
        chk("R8 incremented", flog[0], 32'h28123500);
        set_addr(8'hFF, 8'hFF);
        send_byte(8'h52);
        expect_byte("R8 top high", mdl(32'h28FFFF00));
        expect_byte("R8 top low",  mdl(32'h20FFFF00));
        nfr = 0;
        send_byte(8'h52);
        expect_byte("R8 wrap high", mdl(32'h28000000));
        expect_byte("R8 wrap low",  mdl(32'h20000000));
        chk("R8 wrap frame", flog[0], 32'h28000000);
    endtask

    task automatic t_write;
        set_addr(8'h00, 8'h10);
        nfr = 0;
        send_byte(8'h63); send_byte(8'h5A);
        expect_byte("R9 c reply", 8'h0D);
        send_byte(8'h43); send_byte(8'hA5);
        expect_byte("R9 C reply", 8'h0D);
        chk("R9 c frame", flog[0], 32'h4000105A);
        chk("R9 C frame", flog[1], 32'h480010A5);
        nfr = 0;
        send_byte(8'h52);
        expect_byte("R9 after writes high", mdl(32'h28001100));
        expect_byte("R9 after writes low",  mdl(32'h20001100));
        chk("R9 only C increments", flog[0], 32'h28001100);
    endtask

    task automatic t_bytewide;
        set_dev(8'h86);
        set_addr(8'h03, 8'h21);
        nfr = 0;
        send_byte(8'h52);
        expect_byte("R8 byte-wide read", mdl(32'h19210000));
        send_byte(8'h52);
        expect_byte("R8 byte-wide again", mdl(32'h19210000));
        chk("R8 byte-wide frame count", nfr, 2);
        chk("R8 byte-wide no increment", flog[1], 32'h19210000);
        nfr = 0;
        send_byte(8'h43); send_byte(8'h11);
        expect_byte("R9 C on byte-wide", 8'h3F);
        send_byte(8'h73);
        expect_byte("R13 s on byte-wide", 8'h3F);
        chk("R9 R13 no frame", nfr, 0);
    endtask

    task automatic t_raw;
        set_dev(8'h38);
        nfr = 0;
        send_byte(8'h3A); send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
        expect_byte("R10 raw data", mdl(32'h11223300));
        expect_byte("R10 raw CR", 8'h0D);
        chk("R10 raw frame", flog[0], 32'h11223300);
    endtask

    task automatic t_sig;
        nfr = 0;
        send_byte(8'h73);
        expect_byte("R13 sig 0", mdl(32'h30000200));
        expect_byte("R13 sig 1", mdl(32'h30000100));
        expect_byte("R13 sig 2", mdl(32'h30000000));
        chk("R13 frame count", nfr, 3);
        chk("R13 last frame", flog[2], 32'h30000000);
    endtask

    task automatic t_ddata;
        set_addr(8'h00, 8'h05);
        nfr = 0;
        send_byte(8'h64);
        expect_byte("R12 d data", mdl(32'hA0000500));
        chk("R12 d frame", flog[0], 32'hA0000500);
    endtask

    task automatic t_busy;
        set_addr(8'h00, 8'h40);
        send_byte(8'h52);
        repeat (6) @(negedge clk);
        chk("R11 busy rx_ready", {31'h0, rx_ready}, 32'd0);
        chk("R11 pending tx_valid", {31'h0, tx_valid}, 32'd1);
        expect_byte("R11 first byte", mdl(32'h28004000));
        expect_byte("R11 second byte", mdl(32'h20004000));
        @(negedge clk);
        chk("R11 ready again", {31'h0, rx_ready}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        ntot++;
        nbad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", ntot, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ident();
        t_list();
        t_esc();
        t_gate();
        t_unknown();
        t_enter();
        t_read();
        t_write();
        t_raw();
        t_sig();
        t_ddata();
        t_busy();
        t_bytewide();
        $display("test done: total=%0d bad=%0d", ntot, nbad);
        $finish;
    end
endmodule